// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the device is usable, and afterwards keeps the array alive. After reset it holds NOP during a stabilization wait. It then precharges all banks and issues eight auto-refresh commands, leaving the required gap after each one. Last, it loads the mode register with burst length 8, sequential burst order, CAS latency 2 and burst read/write mode. When that sequence finishes it raises `init_done`.

From then on an interval timer raises `refresh_req` every `REF_INTERVAL` cycles. That is 1500 cycles, or 15 µs, at the 100 MHz controller clock, which fits 4096 row refreshes inside 64 ms. A separate access engine owns the bus between bursts. It hands the bus back by raising `refresh_grant`. The sequencer then issues one auto-refresh and holds `refresh_busy` until the refresh cycle time has passed.

Cycle numbering used below: cycle n is the clock period that follows the n-th rising edge at which `rst_n` is high, counting from 0. Let S = `STAB_CYC`, P = `TRP_CYC`, C = `TRC_CYC`, T = `TMRD_CYC` and I = `REF_INTERVAL`. Let M = S+P+8·C and D = M+T.

Top module: `sdram_init_refresh`

## Requirements
- R1: While `rst_n` is low, cke is 0, cs_n, ras_n, cas_n and we_n are 1, and ba, addr, init_done, refresh_req and refresh_busy are 0.
- R2: Commands are encoded as {cke, cs_n, ras_n, cas_n, we_n}: NOP 10111, precharge 10010, refresh 10001, mode set 10000. In cycles 0 to S-1 the output is NOP.
- R3: In cycle S the output is a precharge with addr bit 10 set and every other addr bit 0, and ba 0.
- R4: Eight refresh commands are issued in cycles S+P+k·C for k = 0..7, with NOP in every cycle between them.
- R5: In cycle M the output is a mode set with ba 0 and addr equal to `MODE_WORD` (default 0x023).
- R6: init_done is 0 before cycle D and is 1 from cycle D until the next reset. refresh_req stays 0 while init_done is 0.
- R7: refresh_req goes to 1 in cycles D+j·I for j ≥ 1. It stays at 1 until a refresh is issued for it.
- R8: A refresh is issued in cycle n+1 exactly when, in cycle n, refresh_req and refresh_grant are both 1 and refresh_busy is 0. In that cycle n+1, refresh_req is 0 unless a new interval expires in the same cycle. If refresh_grant is high while refresh_req is 0, no command is issued.
- R9: refresh_busy is 1 for exactly C cycles, beginning in the cycle of the auto-refresh command.
- R10: In every cycle with no command, the output is NOP with ba and addr both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_grant | input | 1 | Access engine releases the bus for a refresh |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Power-up sequence complete |
| refresh_req | output | 1 | Periodic refresh pending |
| refresh_busy | output | 1 | Auto-refresh in progress |

## Verification
The assertions assume that `refresh_grant` is a clean synchronous level. They do not assume that grant waits for a request. An early, late or held grant must simply have no effect until a request is pending. The stimulus keeps grant high for long stretches, including through busy windows. It also gives grant in sparse single-cycle pulses, and withholds it for longer than one full interval so that a request stays pending. A mid-run reset then checks that the whole power-up script starts again from the first NOP.

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh #(
  parameter int STAB_CYC     = 20000,
  parameter int TRP_CYC      = 2,
  parameter int TRC_CYC      = 7,
  parameter int TMRD_CYC     = 2,
  parameter int REF_INTERVAL = 1500,
  parameter int INIT_REFS    = 8,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_grant,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req,
  output logic              refresh_busy
);
  localparam logic [4:0] C_RST = 5'b01111;
  localparam logic [4:0] C_NOP = 5'b10111;
  localparam logic [4:0] C_PRE = 5'b10010;
  localparam logic [4:0] C_REF = 5'b10001;
  localparam logic [4:0] C_MRS = 5'b10000;
  localparam int M1   = (STAB_CYC > TRC_CYC) ? STAB_CYC : TRC_CYC;
  localparam int M2   = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int WMAX = (M1 > M2) ? M1 : M2;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int IW   = $clog2(REF_INTERVAL + 1);
  localparam int RW   = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;

  typedef enum logic [2:0] {ST_STAB, ST_IREF, ST_MRS, ST_MRD, ST_RUN} st_t;

  st_t              st;
  logic [WW-1:0]    wcnt, bcnt;
  logic [IW-1:0]    ivl;
  logic [RW-1:0]    rcnt;
  logic [4:0]       cmd_q;
  logic             issue, tick;

  assign {cke, cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign issue = (st == ST_RUN) && refresh_req && refresh_grant && !refresh_busy;
  assign tick  = (st == ST_RUN) && (ivl == IW'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_STAB;
      wcnt <= WW'(STAB_CYC);
      rcnt <= '0;
      cmd_q <= C_RST;
      ba <= '0;
      addr <= '0;
      init_done <= 1'b0;
    end else begin
      cmd_q <= C_NOP;
      ba <= '0;
      addr <= '0;
      if (st != ST_RUN && wcnt != '0) wcnt <= wcnt - 1'b1;
      case (st)
        ST_STAB: if (wcnt == '0) begin
          cmd_q <= C_PRE;
          addr <= A10;
          wcnt <= WW'(TRP_CYC - 1);
          rcnt <= '0;
          st <= ST_IREF;
        end
        ST_IREF: if (wcnt == '0) begin
          cmd_q <= C_REF;
          wcnt <= WW'(TRC_CYC - 1);
          rcnt <= rcnt + 1'b1;
          if (rcnt == RW'(INIT_REFS - 1)) st <= ST_MRS;
        end
        ST_MRS: if (wcnt == '0) begin
          cmd_q <= C_MRS;
          addr <= MODE_WORD;
          wcnt <= WW'(TMRD_CYC - 1);
          st <= ST_MRD;
        end
        ST_MRD: if (wcnt == '0) begin
          init_done <= 1'b1;
          st <= ST_RUN;
        end
        default: if (issue) cmd_q <= C_REF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl <= '0;
      refresh_req <= 1'b0;
      refresh_busy <= 1'b0;
      bcnt <= '0;
    end else if (st == ST_RUN) begin
      ivl <= tick ? '0 : ivl + 1'b1;
      refresh_req <= (refresh_req && !issue) || tick;
      if (issue) begin
        refresh_busy <= 1'b1;
        bcnt <= WW'(TRC_CYC - 1);
      end else if (bcnt != '0) begin
        bcnt <= bcnt - 1'b1;
      end else begin
        refresh_busy <= 1'b0;
      end
    end else begin
      ivl <= '0;
    end
  end

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_NOP) |-> (ba == '0 && addr == '0)) else $error("idle bus not zero");
  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE) |-> (addr[10] && ba == '0)) else $error("precharge without A10");
  p_no_early_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req) else $error("request before init");
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done) |-> init_done) else $error("init_done dropped");
  p_ref_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done) && cmd_q == C_REF) |-> $past(refresh_req && refresh_grant))
    else $error("refresh without grant");
  p_busy_on_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cmd_q == C_REF) |-> refresh_busy) else $error("busy missing");
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_grant) |=> refresh_req) else $error("request lost");
endmodule

// File: tb/sdram_init_refresh_test.sv
module sdram_init_refresh_test;
  localparam int S = 40, P = 2, C = 7, T = 2, I = 100;
  localparam int M = S + P + 8 * C;
  localparam int D = M + T;

  logic clk = 0, rst_n = 0, refresh_grant = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req, refresh_busy;
  logic [1:0] ba;
  logic [11:0] addr;
  int compared = 0, mismatched = 0;

  sdram_init_refresh #(.STAB_CYC(S), .TRP_CYC(P), .TRC_CYC(C), .TMRD_CYC(T),
    .REF_INTERVAL(I)) uut (.*);

  always #5 clk = ~clk;

  int ec = 0, m_busy = 0;
  bit m_req = 0, valid = 0;
  logic [4:0] e_cmd;
  logic [11:0] e_addr;
  logic e_done, e_req, e_busy;
  string ctag;

  always @(posedge clk) begin
    bit issue, tick;
    valid = 1;
    e_addr = 0;
    if (!rst_n) begin
      ec = 0; m_req = 0; m_busy = 0;
      e_cmd = 5'b01111; e_done = 0; ctag = "R1";
    end else begin
      e_cmd = 5'b10111; ctag = (ec < S) ? "R2" : "R10";
      if (ec == S) begin e_cmd = 5'b10010; e_addr = 12'h400; ctag = "R3"; end
      else if (ec >= S + P && ec <= S + P + 7 * C && (ec - S - P) % C == 0) begin
        e_cmd = 5'b10001; ctag = "R4";
      end else if (ec == M) begin e_cmd = 5'b10000; e_addr = 12'h023; ctag = "R5"; end
      e_done = (ec >= D);
      if (ec >= D) begin
        issue = (ec > D) && m_req && refresh_grant && m_busy == 0;
        tick = (ec > D) && ((ec - D) % I == 0);
        if (issue) begin e_cmd = 5'b10001; ctag = "R8"; m_busy = C; end
        else if (m_busy > 0) m_busy--;
        m_req = (m_req && !issue) || tick;
      end
      ec++;
    end
    e_req = m_req;
    e_busy = (m_busy > 0);
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at t=%0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (valid) begin
    chk(ctag, {11'd0, cke, cs_n, ras_n, cas_n, we_n}, {11'd0, e_cmd});
    chk(ctag == "R1" ? "R1" : "R10", {2'd0, ba, addr}, {4'd0, e_addr});
    chk(ctag == "R1" ? "R1" : "R6", {15'd0, init_done}, {15'd0, e_done});
    chk(ctag == "R1" ? "R1" : "R7", {15'd0, refresh_req}, {15'd0, e_req});
    chk(ctag == "R1" ? "R1" : "R9", {15'd0, refresh_busy}, {15'd0, e_busy});
  end

  initial begin
    #(20000 * 10);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    refresh_grant = 1;              // R8 R9: grant held high, also across busy
    repeat (600) @(negedge clk);
    refresh_grant = 0;
    for (int i = 0; i < 400; i++) begin  // R8: sparse one-cycle grants
      refresh_grant = (i % 53 == 0);
      @(negedge clk);
    end
    refresh_grant = 0;              // R7: request stays pending past a tick
    repeat (250) @(negedge clk);
    refresh_grant = 1;
    repeat (100) @(negedge clk);
    rst_n = 0;                      // R1: reset mid-run
    repeat (4) @(negedge clk);
    rst_n = 1;                      // R2..R6: script restarts
    repeat (300) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule